// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Unit

This block watches the buffers and error lines around a UART and turns what it sees into a masked interrupt. It observes push and pop strobes on three queues: a receive FIFO, a transmit FIFO and a small host-side write FIFO. From these strobes it keeps an occupancy count for each queue and a word of empty and full flags. It does not hold the data itself. The serial shifters, baud timing and storage arrays sit outside the block and reach it only as single-cycle strobes.

Every noteworthy event sets one bit in a sticky twelve-bit status vector. The events are accepted pushes and pops, pushes into a full queue, reads of an empty queue, framing and parity errors, a protocol-mode read error, and crossings of two programmable thresholds. Software clears status bits by writing ones. It can hide any bit from the interrupt line with a per-bit mask. The interrupt output is a registered OR of the unmasked status bits.

Top module: `uart_fifo_irq_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all three counts go to 0, status and mask go to 0 and `irq` goes low, so `flags` reads 0x0E.
- R2: A push is accepted only when its queue is not full, and a pop only when it is not empty; both are judged on the count before the edge. An accepted push adds one, an accepted pop subtracts one, and both in the same cycle leave the count unchanged. The capacities are 256 for the receive and transmit queues and 4 for the write queue.
- R3: The `flags` layout is as follows. Bit 0 is always 0. Bits 1, 2 and 3 are receive, write and transmit empty. Bits 4, 5 and 6 are receive, write and transmit full.
- R4: The status bits are set by these events. Bit 2 is a framing-error pulse, bit 3 a parity-error pulse and bit 10 a protocol read-error pulse. Bit 7 is an accepted transmit pop, bit 8 an accepted receive push and bit 9 an accepted write-queue pop. Bit 6 always reads 0 in both status and mask. Each bit becomes visible one edge after its event.
- R5: A receive push while the receive queue is full (and not popped in the same cycle) sets status bit 4, and the byte is dropped: the count stays at 256.
- R6: An accepted receive push whose count before the push is greater than or equal to `rx_afull_thr` sets status bit 5.
- R7: An accepted transmit pop whose count before the pop is less than or equal to `tx_aempty_thr` sets status bit 11.
- R8: When `clr_we` is high, each 1 in `clr_bits` clears the matching status bit. A 0 leaves that bit unchanged.
- R9: When a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.
- R10: When `mask_we` is high, the mask loads `mask_bits`. A masked status bit is still recorded but does not drive `irq`. `irq` equals the OR of status AND NOT mask, delayed by one register.
- R11: A receive pop while the receive queue is empty sets status bit 0. A write-queue push while that queue is full sets status bit 1. In both cases the count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Byte arriving into the receive queue |
| rx_pop | input | 1 | Read from the receive queue |
| tx_push | input | 1 | Byte written into the transmit queue |
| tx_pop | input | 1 | Byte taken by the transmitter |
| wf_push | input | 1 | Host write into the write queue |
| wf_pop | input | 1 | Write-queue entry drained |
| rx_frame_err | input | 1 | Missing stop bit pulse |
| rx_parity_err | input | 1 | Parity mismatch pulse |
| proto_rd_err | input | 1 | Protocol-mode receive read error pulse |
| rx_afull_thr | input | 9 | Receive almost-full threshold |
| tx_aempty_thr | input | 9 | Transmit almost-empty threshold |
| clr_we | input | 1 | Write strobe for the clear-by-one port |
| clr_bits | input | 12 | Status bits to clear |
| mask_we | input | 1 | Mask load strobe |
| mask_bits | input | 12 | New mask value |
| status | output | 12 | Sticky event vector |
| mask | output | 12 | Current mask |
| flags | output | 7 | Empty/full flag word |
| rx_count | output | 9 | Receive occupancy |
| tx_count | output | 9 | Transmit occupancy |
| wf_count | output | 3 | Write-queue occupancy |
| irq | output | 1 | Interrupt, active high |

## Verification
The receive queue is filled one push at a time across its threshold. This separates a greater-or-equal comparison from a strict one, and a count taken before the push from one taken after it. It then pushes past capacity and drains past empty, which checks that rejected strobes leave counts untouched while still setting their own status bits. A transmit drain across its threshold and a simultaneous push and pop check the other comparison and the cancel rule. Clear writes with zero bits, with a clash against a hardware set, and with mask changes followed edge by edge show the clear-by-one rule, the priority of a set over a clear, and the one-register lag of `irq`.

// File: rtl/uart_stat_pkg.sv
`timescale 1ns/1ps
package uart_stat_pkg;
  localparam int IRQ_W       = 12;
  localparam int B_RD_EMPTY  = 0;
  localparam int B_WF_OVF    = 1;
  localparam int B_FRAME     = 2;
  localparam int B_PARITY    = 3;
  localparam int B_RX_OVF    = 4;
  localparam int B_RX_AFULL  = 5;
  localparam int B_RSVD      = 6;
  localparam int B_TX_POP    = 7;
  localparam int B_RX_PUSH   = 8;
  localparam int B_WF_POP    = 9;
  localparam int B_PROTO     = 10;
  localparam int B_TX_AEMPTY = 11;

  localparam int FLAG_W      = 7;
  localparam int F_RX_EMPTY  = 1;
  localparam int F_WF_EMPTY  = 2;
  localparam int F_TX_EMPTY  = 3;
  localparam int F_RX_FULL   = 4;
  localparam int F_WF_FULL   = 5;
  localparam int F_TX_FULL   = 6;
endpackage

// File: rtl/fifo_level_trk.sv
`timescale 1ns/1ps
module fifo_level_trk #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_V);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push_ok && !pop_ok) begin
      cnt_q <= cnt_q + ONE;
    end else if (pop_ok && !push_ok) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_V);
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> full);
  p_empty_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty);
  p_both_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_status_vec.sv
`timescale 1ns/1ps
module irq_status_vec #(
  parameter int             W    = 12,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [W-1:0] mask_bits,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] stat_q, mask_q, clr_v, stat_d;
  logic         irq_q;

  assign clr_v  = clr_we ? clr_bits : '0;
  assign stat_d = ((stat_q & ~clr_v) | set) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_bits & IMPL;
      irq_q  <= |(stat_q & ~mask_q);
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((stat_q & $past(set & IMPL)) == $past(set & IMPL)));
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set == '0) |=> ((stat_q & $past(clr_bits)) == '0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_we && set == '0) |=> $stable(stat_q));
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~mask_q) == '0) |=> !irq_q);
endmodule

// File: rtl/uart_fifo_irq_unit.sv
`timescale 1ns/1ps
module uart_fifo_irq_unit
  import uart_stat_pkg::*;
#(
  parameter int RX_DEPTH = 256,
  parameter int TX_DEPTH = 256,
  parameter int WF_DEPTH = 4,
  parameter int RX_CW    = $clog2(RX_DEPTH + 1),
  parameter int TX_CW    = $clog2(TX_DEPTH + 1),
  parameter int WF_CW    = $clog2(WF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              wf_push,
  input  logic              wf_pop,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              proto_rd_err,
  input  logic [RX_CW-1:0]  rx_afull_thr,
  input  logic [TX_CW-1:0]  tx_aempty_thr,
  input  logic              clr_we,
  input  logic [IRQ_W-1:0]  clr_bits,
  input  logic              mask_we,
  input  logic [IRQ_W-1:0]  mask_bits,
  output logic [IRQ_W-1:0]  status,
  output logic [IRQ_W-1:0]  mask,
  output logic [FLAG_W-1:0] flags,
  output logic [RX_CW-1:0]  rx_count,
  output logic [TX_CW-1:0]  tx_count,
  output logic [WF_CW-1:0]  wf_count,
  output logic              irq
);
  localparam logic [IRQ_W-1:0] IMPL = ~(IRQ_W'(1) << B_RSVD);

  logic rx_empty, rx_full, tx_empty, tx_full, wf_empty, wf_full;
  logic [IRQ_W-1:0] set_v;

  fifo_level_trk #(.DEPTH(RX_DEPTH), .CW(RX_CW)) u_rx_lvl (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
    .count(rx_count), .empty(rx_empty), .full(rx_full));

  fifo_level_trk #(.DEPTH(TX_DEPTH), .CW(TX_CW)) u_tx_lvl (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
    .count(tx_count), .empty(tx_empty), .full(tx_full));

  fifo_level_trk #(.DEPTH(WF_DEPTH), .CW(WF_CW)) u_wf_lvl (
    .clk(clk), .rst(rst), .push(wf_push), .pop(wf_pop),
    .count(wf_count), .empty(wf_empty), .full(wf_full));

  always_comb begin
    set_v              = '0;
    set_v[B_RD_EMPTY]  = rx_pop && rx_empty;
    set_v[B_WF_OVF]    = wf_push && wf_full;
    set_v[B_FRAME]     = rx_frame_err;
    set_v[B_PARITY]    = rx_parity_err;
    set_v[B_RX_OVF]    = rx_push && rx_full;
    set_v[B_RX_AFULL]  = rx_push && !rx_full && (rx_count >= rx_afull_thr);
    set_v[B_TX_POP]    = tx_pop && !tx_empty;
    set_v[B_RX_PUSH]   = rx_push && !rx_full;
    set_v[B_WF_POP]    = wf_pop && !wf_empty;
    set_v[B_PROTO]     = proto_rd_err;
    set_v[B_TX_AEMPTY] = tx_pop && !tx_empty && (tx_count <= tx_aempty_thr);
  end

  always_comb begin
    flags             = '0;
    flags[F_RX_EMPTY] = rx_empty;
    flags[F_WF_EMPTY] = wf_empty;
    flags[F_TX_EMPTY] = tx_empty;
    flags[F_RX_FULL]  = rx_full;
    flags[F_WF_FULL]  = wf_full;
    flags[F_TX_FULL]  = tx_full;
  end

  irq_status_vec #(.W(IRQ_W), .IMPL(IMPL)) u_stat (
    .clk(clk), .rst(rst), .set(set_v),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .mask_we(mask_we), .mask_bits(mask_bits),
    .status(status), .mask(mask), .irq(irq));

  p_rx_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !rx_pop && flags[F_RX_FULL]) |=> (status[B_RX_OVF] && $stable(rx_count)));
  p_rx_afull_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !flags[F_RX_FULL] && rx_count >= rx_afull_thr) |=> status[B_RX_AFULL]);
  p_tx_aempty_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !flags[F_TX_EMPTY] && tx_count <= tx_aempty_thr) |=> status[B_TX_AEMPTY]);
  p_rd_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_push && flags[F_RX_EMPTY]) |=> (status[B_RD_EMPTY] && rx_count == '0));
endmodule

// File: tb/test_uart_fifo_irq_unit.sv
`timescale 1ns/1ps
module test_uart_fifo_irq_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, wf_push = 0, wf_pop = 0;
  logic rx_frame_err = 0, rx_parity_err = 0, proto_rd_err = 0;
  logic [8:0] rx_afull_thr = 9'd250, tx_aempty_thr = 9'd2;
  logic clr_we = 0, mask_we = 0;
  logic [11:0] clr_bits = '0, mask_bits = '0;
  logic [11:0] status, mask;
  logic [6:0]  flags;
  logic [8:0]  rx_count, tx_count;
  logic [2:0]  wf_count;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_fifo_irq_unit i_uart_fifo_irq_unit (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_pop(tx_pop), .wf_push(wf_push), .wf_pop(wf_pop),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .proto_rd_err(proto_rd_err), .rx_afull_thr(rx_afull_thr),
    .tx_aempty_thr(tx_aempty_thr), .clr_we(clr_we), .clr_bits(clr_bits),
    .mask_we(mask_we), .mask_bits(mask_bits), .status(status), .mask(mask),
    .flags(flags), .rx_count(rx_count), .tx_count(tx_count),
    .wf_count(wf_count), .irq(irq));

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_we = 1; clr_bits = 12'hFFF; cyc(); clr_we = 0; clr_bits = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc_n);
      finish_run();
    end
  end

  task automatic t_reset();
    chk("R1 rx_count", 32'(rx_count), 0);
    chk("R1 tx_count", 32'(tx_count), 0);
    chk("R1 wf_count", 32'(wf_count), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 mask", 32'(mask), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 R3 flags", 32'(flags), 32'h0E);
  endtask

  task automatic t_rx_fill();
    rx_afull_thr = 9'd250;
    for (int i = 0; i < 250; i++) begin rx_push = 1; cyc(); end
    rx_push = 0;
    chk("R2 rx_count 250", 32'(rx_count), 250);
    chk("R6 afull below thr", 32'(status[5]), 0);
    chk("R4 rx push bit8", 32'(status[8]), 1);
    rx_push = 1; cyc(); rx_push = 0;
    chk("R6 afull at thr", 32'(status[5]), 1);
    for (int i = 0; i < 5; i++) begin rx_push = 1; cyc(); end
    rx_push = 0;
    chk("R2 rx_count full", 32'(rx_count), 256);
    chk("R3 flags rx full", 32'(flags), 32'h1C);
    clear_all();
    rx_push = 1; cyc(); rx_push = 0;
    chk("R5 overflow bit", 32'(status), 32'h010);
    chk("R5 count kept", 32'(rx_count), 256);
    for (int i = 0; i < 256; i++) begin rx_pop = 1; cyc(); end
    rx_pop = 0;
    chk("R2 rx drained", 32'(rx_count), 0);
    clear_all();
    rx_pop = 1; cyc(); rx_pop = 0;
    chk("R11 read empty", 32'(status), 32'h001);
    chk("R11 count kept", 32'(rx_count), 0);
    chk("R3 flags idle", 32'(flags), 32'h0E);
    clear_all();
  endtask

  task automatic t_tx();
    tx_aempty_thr = 9'd2;
    for (int i = 0; i < 4; i++) begin tx_push = 1; cyc(); end
    tx_push = 0;
    chk("R2 tx_count 4", 32'(tx_count), 4);
    chk("R3 tx not empty", 32'(flags), 32'h06);
    tx_pop = 1; cyc(); cyc(); tx_pop = 0;
    chk("R7 aempty above thr", 32'(status[11]), 0);
    chk("R4 tx pop bit7", 32'(status[7]), 1);
    tx_pop = 1; cyc(); tx_pop = 0;
    chk("R7 aempty at thr", 32'(status[11]), 1);
    chk("R2 tx_count 1", 32'(tx_count), 1);
    clear_all();
    tx_push = 1; tx_pop = 1; cyc(); tx_push = 0; tx_pop = 0;
    chk("R2 push+pop count", 32'(tx_count), 1);
    chk("R4 R7 push+pop events", 32'(status), 32'h880);
    tx_pop = 1; cyc(); tx_pop = 0;
    clear_all();
  endtask

  task automatic t_wf();
    for (int i = 0; i < 4; i++) begin wf_push = 1; cyc(); end
    wf_push = 0;
    chk("R2 wf_count 4", 32'(wf_count), 4);
    chk("R3 wf full flag", 32'(flags), 32'h2A);
    chk("R11 no err yet", 32'(status), 0);
    wf_push = 1; cyc(); wf_push = 0;
    chk("R11 write full bit1", 32'(status), 32'h002);
    chk("R11 wf count kept", 32'(wf_count), 4);
    clear_all();
    wf_pop = 1; cyc(); wf_pop = 0;
    chk("R4 wf pop bit9", 32'(status), 32'h200);
    chk("R2 wf_count 3", 32'(wf_count), 3);
    for (int i = 0; i < 3; i++) begin wf_pop = 1; cyc(); end
    wf_pop = 0;
    clear_all();
  endtask

  task automatic t_w1c();
    rx_frame_err = 1; rx_parity_err = 1; proto_rd_err = 1; cyc();
    rx_frame_err = 0; rx_parity_err = 0; proto_rd_err = 0;
    chk("R4 err pulses", 32'(status), 32'h40C);
    clr_we = 1; clr_bits = 12'h000; cyc(); clr_we = 0;
    chk("R8 zero no effect", 32'(status), 32'h40C);
    clr_we = 0; clr_bits = 12'hFFF; cyc(); clr_bits = '0;
    chk("R8 no strobe no effect", 32'(status), 32'h40C);
    clr_we = 1; clr_bits = 12'h004; cyc(); clr_we = 0; clr_bits = '0;
    chk("R8 one clears", 32'(status), 32'h408);
    rx_frame_err = 1; clr_we = 1; clr_bits = 12'h40C; cyc();
    rx_frame_err = 0; clr_we = 0; clr_bits = '0;
    chk("R9 set wins", 32'(status), 32'h004);
    clear_all();
  endtask

  task automatic t_mask();
    mask_we = 1; mask_bits = 12'hFFF; cyc(); mask_we = 0;
    chk("R10 R4 mask bit6 zero", 32'(mask), 32'hFBF);
    rx_frame_err = 1; cyc(); rx_frame_err = 0;
    chk("R10 masked recorded", 32'(status), 32'h004);
    cyc();
    chk("R10 masked irq low", 32'(irq), 0);
    mask_we = 1; mask_bits = 12'h000; cyc(); mask_we = 0;
    chk("R10 irq lag", 32'(irq), 0);
    cyc();
    chk("R10 irq high", 32'(irq), 1);
    clear_all();
    chk("R10 irq held one cycle", 32'(irq), 1);
    cyc();
    chk("R10 irq dropped", 32'(irq), 0);
  endtask

  initial begin
    repeat (4) cyc();
    rst = 0;
    t_reset();
    t_rx_fill();
    t_tx();
    t_wf();
    t_w1c();
    t_mask();
    finish_run();
  end
endmodule